// File: doc/BRIEF.md
# Gated Integrator Acquisition Sequencer

This block times the acquisition of an eight-channel gated-integrator front end that shares one simultaneously sampling ADC. A rising edge on the trigger input opens an integration window around the beam arrival. When the window closes, the track-and-hold stages are frozen and one conversion of all channels is requested. The integrators are then cleared for a long reset interval. A second window and conversion follow, and that second conversion measures the pedestal (baseline) that is later subtracted from the signal.

The sequencer counts baseline cycles from reset. On every twelfth one it fires a short LED flash into the detector during the baseline window, and it marks that conversion as a self-test sample. Downstream logic can then compare the result against a trip limit. Every conversion carries a two-bit tag, so the consumer of the ADC data knows whether a word is a signal, baseline or test sample.

All durations are given in physical units and converted to clock cycles from the clock-frequency parameter. The trigger is expected at 360 Hz, which leaves ample idle time after each roughly 1.04 ms sequence.

Top module: `gi_acq_seq`

## Requirements
- R1: After a synchronous reset, every output is low, `sample_tag_o` is 0 and `ovl_err_o` is clear.
- R2: A low-to-high transition of `trig_i` seen while idle raises `gate_o` at the next clock edge. `gate_o` then stays high for exactly GATE_CYC cycles, where GATE_CYC = ceil(CLK_HZ*GATE_US/1e6).
- R3: In the first cycle after the signal window ends, `hold_o` is high and `conv_start_o` is high for exactly one cycle. `sample_tag_o` is 1 (signal) during that cycle.
- R4: `hold_o` stays high until the sequencer has sampled `adc_busy_i` low in a cycle after the strobe. The ADC must raise busy from the cycle after the strobe. For a busy pulse of L cycles, `hold_o` is high for L+2 cycles.
- R5: `int_rst_o` rises as the signal `hold_o` falls, stays high for exactly RST_CYC = ceil(CLK_HZ*RST_US/1e6) cycles, and never overlaps `gate_o`.
- R6: A baseline window of GATE_CYC cycles starts in the cycle after `int_rst_o` falls. It is followed by the same conversion handshake, with `sample_tag_o` 2 (baseline).
- R7: Baseline cycles are numbered from 1 after reset. On numbers that are multiples of TEST_EVERY (default 12), `led_o` rises together with the baseline `gate_o` and stays high for ceil(CLK_HZ*LED_NS/1e9) cycles (at least 1). That conversion is tagged 3 (test) instead of 2.
- R8: A rising trigger edge that arrives while a sequence runs leaves the sequence timing unchanged. It sets `ovl_err_o`, which stays set until reset.
- R9: Only a low-to-high transition starts a sequence. A trigger held high through a whole sequence causes no second sequence and no overlap error.
- R10: `sample_tag_o` is 0 whenever `hold_o` is low, and it holds its value while `hold_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Timing trigger, synchronous to clk; rising edge starts a sequence |
| adc_busy_i | input | 1 | ADC conversion in progress |
| gate_o | output | 1 | Integration window open |
| hold_o | output | 1 | Track-and-hold stages in hold |
| int_rst_o | output | 1 | Integrator reset |
| conv_start_o | output | 1 | One-cycle ADC convert strobe |
| led_o | output | 1 | LED self-test flash |
| sample_tag_o | output | 2 | 0 none, 1 signal, 2 baseline, 3 test |
| ovl_err_o | output | 1 | Sticky flag: trigger arrived during a running sequence |

## Verification
Several orderings are checked by assertions on every cycle. The strobe and hold must appear together as a window closes, the strobe lasts a single cycle, and hold is released only after busy was seen low. The integrator reset never coincides with a window and hands over directly to the baseline window. The LED flash stays inside a window, the tag is stable during hold, and the overlap flag is sticky. Only the bench scenarios can show the exact lengths of the windows, of the reset interval and of the flash. They also show the twelve-cycle cadence of the test sample, and that ignored or held triggers leave the timing untouched.

// File: rtl/gi_seq_pkg.sv
package gi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SIG_GATE, ST_SIG_CONV, ST_SIG_WAIT,
    ST_INT_RST, ST_BASE_GATE, ST_BASE_CONV, ST_BASE_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0, TAG_SIGNAL = 2'd1, TAG_BASE = 2'd2, TAG_TEST = 2'd3
  } sample_tag_t;

  // Rounds a physical duration up to whole clock cycles, never below one.
  function automatic int unsigned clk_cycles(longint unsigned hz,
                                             longint unsigned amount,
                                             longint unsigned per_sec);
    longint unsigned prod;
    prod = (hz * amount + per_sec - 1) / per_sec;
    return (prod == 0) ? 32'd1 : 32'(prod);
  endfunction

endpackage

// File: rtl/gi_edge_det.sv
module gi_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/gi_interval.sv
module gi_interval #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/gi_test_sched.sv
module gi_test_sched #(
  parameter int PERIOD = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic test_now_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign test_now_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (adv_i)     cnt_q <= test_now_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/gi_pulse.sv
module gi_pulse #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (fire_i)        cnt_q <= W'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/gi_acq_seq.sv
module gi_acq_seq #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned GATE_US    = 20,
  parameter int unsigned RST_US     = 1000,
  parameter int unsigned LED_NS     = 100,
  parameter int unsigned TEST_EVERY = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_i,
  input  logic       adc_busy_i,
  output logic       gate_o,
  output logic       hold_o,
  output logic       int_rst_o,
  output logic       conv_start_o,
  output logic       led_o,
  output logic [1:0] sample_tag_o,
  output logic       ovl_err_o
);
  import gi_seq_pkg::*;

  localparam int unsigned GATE_CYC = clk_cycles(CLK_HZ, GATE_US, 1_000_000);
  localparam int unsigned RST_CYC  = clk_cycles(CLK_HZ, RST_US, 1_000_000);
  localparam int unsigned LED_CYC  = clk_cycles(CLK_HZ, LED_NS, 1_000_000_000);
  localparam int unsigned MAX_CYC  = (GATE_CYC > RST_CYC) ? GATE_CYC : RST_CYC;
  localparam int          CNT_W    = $clog2(MAX_CYC + 1);

  seq_state_t  state_q, state_n;
  sample_tag_t tag_n;
  logic        trig_rise, expired, load, base_start, test_now, test_cyc_q;
  logic [CNT_W-1:0] load_val;

  gi_edge_det u_edge (
    .clk(clk), .rst(rst), .sig_i(trig_i), .rise_o(trig_rise)
  );

  gi_interval #(.W(CNT_W)) u_interval (
    .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val), .expired_o(expired)
  );

  gi_test_sched #(.PERIOD(TEST_EVERY)) u_sched (
    .clk(clk), .rst(rst), .adv_i(base_start), .test_now_o(test_now)
  );

  gi_pulse #(.LEN(LED_CYC)) u_led (
    .clk(clk), .rst(rst), .fire_i(base_start && test_now), .pulse_o(led_o)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:      if (trig_rise)   state_n = ST_SIG_GATE;
      ST_SIG_GATE:  if (expired)     state_n = ST_SIG_CONV;
      ST_SIG_CONV:                   state_n = ST_SIG_WAIT;
      ST_SIG_WAIT:  if (!adc_busy_i) state_n = ST_INT_RST;
      ST_INT_RST:   if (expired)     state_n = ST_BASE_GATE;
      ST_BASE_GATE: if (expired)     state_n = ST_BASE_CONV;
      ST_BASE_CONV:                  state_n = ST_BASE_WAIT;
      ST_BASE_WAIT: if (!adc_busy_i) state_n = ST_IDLE;
      default:                       state_n = ST_IDLE;
    endcase
  end

  assign base_start = (state_n == ST_BASE_GATE) && (state_q != ST_BASE_GATE);
  assign load = (state_n != state_q) &&
                (state_n == ST_SIG_GATE || state_n == ST_INT_RST || state_n == ST_BASE_GATE);
  assign load_val = (state_n == ST_INT_RST) ? CNT_W'(RST_CYC - 1) : CNT_W'(GATE_CYC - 1);

  always_comb begin
    unique case (state_n)
      ST_SIG_CONV, ST_SIG_WAIT:   tag_n = TAG_SIGNAL;
      ST_BASE_CONV, ST_BASE_WAIT: tag_n = test_cyc_q ? TAG_TEST : TAG_BASE;
      default:                    tag_n = TAG_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      test_cyc_q   <= 1'b0;
      ovl_err_o    <= 1'b0;
      gate_o       <= 1'b0;
      hold_o       <= 1'b0;
      int_rst_o    <= 1'b0;
      conv_start_o <= 1'b0;
      sample_tag_o <= TAG_NONE;
    end else begin
      state_q      <= state_n;
      if (base_start) test_cyc_q <= test_now;
      if (trig_rise && state_q != ST_IDLE) ovl_err_o <= 1'b1;
      gate_o       <= (state_n == ST_SIG_GATE) || (state_n == ST_BASE_GATE);
      hold_o       <= (state_n == ST_SIG_CONV) || (state_n == ST_SIG_WAIT) ||
                      (state_n == ST_BASE_CONV) || (state_n == ST_BASE_WAIT);
      int_rst_o    <= (state_n == ST_INT_RST);
      conv_start_o <= (state_n == ST_SIG_CONV) || (state_n == ST_BASE_CONV);
      sample_tag_o <= tag_n;
    end
  end

  // Window close hands straight over to hold plus the convert strobe.
  assert_gate_to_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o) |-> (hold_o && conv_start_o));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  assert_hold_waits_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> !$past(adc_busy_i));

  assert_reset_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(int_rst_o && gate_o));

  assert_reset_to_base_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(int_rst_o) |-> gate_o);

  assert_led_in_gate_R7: assert property (@(posedge clk) disable iff (rst)
    led_o |-> gate_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovl_err_o |=> ovl_err_o);

  assert_tag_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_o && $past(hold_o)) |-> $stable(sample_tag_o));
endmodule

// File: tb/gi_acq_seq_test.sv
module gi_acq_seq_test;
  localparam int unsigned CLK_HZ     = 2_000_000;
  localparam int unsigned GATE_US    = 20;
  localparam int unsigned RST_US     = 1000;
  localparam int unsigned LED_NS     = 2000;
  localparam int unsigned TEST_EVERY = 12;
  localparam int          LIMIT      = 10000;

  logic clk = 1'b0, rst = 1'b1, trig = 1'b0, busy;
  logic gate, hold, irst, conv, led, ovl;
  logic [1:0] tag;
  int checks = 0, errors = 0, busy_len = 0, busy_cnt = 0, base_n = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gi_acq_seq #(.CLK_HZ(CLK_HZ), .GATE_US(GATE_US), .RST_US(RST_US),
               .LED_NS(LED_NS), .TEST_EVERY(TEST_EVERY)) uut (
    .clk(clk), .rst(rst), .trig_i(trig), .adc_busy_i(busy),
    .gate_o(gate), .hold_o(hold), .int_rst_o(irst), .conv_start_o(conv),
    .led_o(led), .sample_tag_o(tag), .ovl_err_o(ovl)
  );

  // ADC model: busy for busy_len cycles starting the cycle after the strobe.
  always_ff @(posedge clk) begin
    if (conv) busy_cnt <= busy_len;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign busy = (busy_cnt != 0);

  function automatic int exp_cycles(longint unsigned amount, longint unsigned per);
    longint unsigned p = (longint'(CLK_HZ) * amount + per - 1) / per;
    return (p == 0) ? 1 : int'(p);
  endfunction

  function automatic int exp_hold(int blen);
    return blen + 2;
  endfunction

  localparam int G_EXP = (CLK_HZ * 64'd0 == 0) ? 40 : 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit hold_trig, input bit inject, input int b1, input int b2);
    int w, lw, g, r, ex_tag;
    bit is_test;
    g = exp_cycles(GATE_US, 1_000_000);
    r = exp_cycles(RST_US, 1_000_000);
    busy_len = b1;
    @(negedge clk) trig = 1'b1;
    @(negedge clk);
    if (!hold_trig) trig = 1'b0;
    check(gate == 1'b1, "R2 gate latency", gate, 1);
    w = 0;
    while (gate && w < LIMIT) begin w++; @(negedge clk); end
    check(w == g, "R2 signal gate width", w, g);
    check(hold && conv, "R3 hold+strobe at gate end", {hold, conv}, 3);
    check(tag == 2'd1, "R3 signal tag", tag, 1);
    @(negedge clk);
    check(conv == 1'b0, "R3 strobe one cycle", conv, 0);
    w = 1;
    while (hold && w < LIMIT) begin w++; @(negedge clk); end
    check(w == exp_hold(b1), "R4 signal hold width", w, exp_hold(b1));
    check(tag == 2'd0, "R10 tag cleared after hold", tag, 0);
    check(irst == 1'b1, "R5 reset follows hold", irst, 1);
    busy_len = b2;
    w = 0;
    while (irst && w < LIMIT) begin
      w++;
      if (inject && w == 10) trig = 1'b1;
      if (inject && w == 12) trig = 1'b0;
      check(!(irst && gate), "R5 no gate during reset", gate, 0);
      @(negedge clk);
    end
    check(w == r, "R5 R8 reset width", w, r);
    if (inject) check(ovl == 1'b1, "R8 overlap flag", ovl, 1);
    check(gate == 1'b1, "R6 base gate after reset", gate, 1);
    base_n++;
    is_test = (base_n % TEST_EVERY) == 0;
    check(led == is_test, "R7 led at base gate start", led, is_test);
    w = 0; lw = 0;
    while (gate && w < LIMIT) begin
      w++;
      if (led) lw++;
      @(negedge clk);
    end
    check(w == g, "R6 base gate width", w, g);
    if (is_test)
      check(lw == exp_cycles(LED_NS, 1_000_000_000), "R7 led width", lw,
            exp_cycles(LED_NS, 1_000_000_000));
    ex_tag = is_test ? 3 : 2;
    check(hold && conv, "R6 base strobe", {hold, conv}, 3);
    check(tag == 2'(ex_tag), "R6 R7 base tag", tag, ex_tag);
    @(negedge clk);
    w = 1;
    while (hold && w < LIMIT) begin w++; @(negedge clk); end
    check(w == exp_hold(b2), "R4 base hold width", w, exp_hold(b2));
    check(!gate && !irst && tag == 2'd0, "R10 idle after sequence", {gate, irst, tag}, 0);
    if (hold_trig) begin
      repeat (30) @(negedge clk);
      check(gate == 1'b0, "R9 held trigger no restart", gate, 0);
      check(ovl == 1'b0, "R9 held trigger no error", ovl, 0);
      trig = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({gate, hold, irst, conv, led, tag, ovl} == 8'd0, "R1 reset state",
          {gate, hold, irst, conv, led, tag, ovl}, 0);
    run_seq(1'b0, 1'b0, 0, 0);
    run_seq(1'b1, 1'b0, 3, 5);
    check(ovl == 1'b0, "R8 flag clear before overlap", ovl, 0);
    for (int i = 0; i < 22; i++) begin
      repeat ($urandom_range(3, 40)) @(negedge clk);
      run_seq(1'b0, (i == 5), $urandom_range(0, 7), $urandom_range(0, 7));
      if (i > 5) check(ovl == 1'b1, "R8 flag sticky", ovl, 1);
    end
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({gate, hold, irst, conv, led, tag, ovl} == 8'd0, "R1 mid-sequence reset",
          {gate, hold, irst, conv, led, tag, ovl}, 0);
    repeat (50) @(negedge clk);
    check(gate == 1'b0 && irst == 1'b0, "R1 stays idle after reset", {gate, irst}, 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule